// File: doc/BRIEF.md
# Auto-Advancing Circular Read Buffer

This block keeps a short, repeating list of constant values behind a single register name. Before a loop starts, software writes the values through a write port. Each write goes to the next entry in turn. A configure command sets how many entries take part in the cycle, from one up to the full depth.

While the loop runs, the read port always shows the entry at the current read position. Each read enable moves that position forward by one. After the last used entry, the position returns to entry zero. One register specifier can therefore hand out a whole pattern of loop-invariant operands in rotation.

Writes use their own position counter. That counter wraps at the same configured size as the read position. A configure command restarts both counters.

Top module: `circ_read_buf`

## Requirements
- R1: After reset the active size equals DEPTH (8), all entries hold zero, and both positions are zero, so `rd_data` reads 0.
- R2: `rd_data` always presents, with no clock delay, the entry at the current read position.
- R3: On a clock edge with `rd_en` high and no accepted configure, the read position increases by one. Without `rd_en` and without an accepted configure, the read position holds.
- R4: When the read position advances from entry size-1, it becomes 0.
- R5: On a clock edge with `wr_en` high and no accepted configure, `wr_data` is stored at the write position. The write position then advances by one, wrapping from size-1 to 0.
- R6: A configure (`cfg_valid` high) with `cfg_size` between 1 and DEPTH is accepted. It loads the size and sets both positions to 0, and stored entries keep their values.
- R7: A configure with `cfg_size` of 0 or above DEPTH has no effect. Reads and writes in that cycle proceed as if no configure were present.
- R8: When a configure is accepted, `rd_en` and `wr_en` in the same cycle are ignored: no entry changes and neither position advances.
- R9: With size 1, every read returns entry 0, and every write lands in entry 0.
- R10: A read and a write in the same cycle both take effect. `rd_data` in that cycle shows the entry as it was before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configure command strobe |
| cfg_size | input | SIZE_W (4) | Number of entries in the cycle, 1..DEPTH |
| wr_en | input | 1 | Write strobe: store `wr_data` at the write position |
| wr_data | input | DATA_W (32) | Value to store |
| rd_en | input | 1 | Read strobe: advance the read position |
| rd_data | output | DATA_W (32) | Entry at the current read position |

## Verification
A wrong read position shows up on `rd_data` right away. It becomes visible as soon as the neighbouring entries hold distinct values, so every fill uses unique data. A wrong size or a wrong write position shows up later, when a read lands on an entry that was skipped or overwritten. The reference model is compared on every cycle so that such an error is caught on the first read that reaches it. Configure commands that are out of range, or that coincide with reads and writes, are followed by read sequences long enough to expose any pointer movement they should not have caused.

// File: rtl/crb_pkg.sv
package crb_pkg;

    // Widest position the helper below supports.
    localparam int unsigned POS_MAX_W = 8;

    // Step a position by one and return to zero at the limit.
    function automatic logic [POS_MAX_W-1:0] wrap_next(
        input logic [POS_MAX_W-1:0] pos,
        input logic [POS_MAX_W-1:0] lim
    );
        logic [POS_MAX_W:0] nxt;
        nxt = {1'b0, pos} + {{POS_MAX_W{1'b0}}, 1'b1};
        if (nxt >= {1'b0, lim}) begin
            return '0;
        end
        return nxt[POS_MAX_W-1:0];
    endfunction

endpackage

// File: rtl/crb_cfg.sv
module crb_cfg #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned SIZE_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [SIZE_W-1:0] cfg_size,
    output logic              accept_o,
    output logic [SIZE_W-1:0] size_o
);

    localparam logic [SIZE_W-1:0] SIZE_RST = SIZE_W'(DEPTH);

    typedef struct packed {
        logic [SIZE_W-1:0] size;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic       in_range;

    always_comb begin
        in_range = (cfg_size != '0) && (cfg_size <= SIZE_RST);
        accept_o = cfg_valid && in_range;
        st_d     = st_q;
        if (accept_o) begin
            st_d.size = cfg_size;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.size <= SIZE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign size_o = st_q.size;

endmodule

// File: rtl/crb_ptr.sv
module crb_ptr #(
    parameter int unsigned PTR_W  = 3,
    parameter int unsigned SIZE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [SIZE_W-1:0] size,
    output logic [PTR_W-1:0]  pos_o
);

    typedef struct packed {
        logic [PTR_W-1:0] pos;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [crb_pkg::POS_MAX_W-1:0] stepped;

    always_comb begin
        stepped = crb_pkg::wrap_next(crb_pkg::POS_MAX_W'(st_q.pos),
                                     crb_pkg::POS_MAX_W'(size));
        st_d = st_q;
        if (clear) begin
            st_d.pos = '0;
        end else if (step) begin
            st_d.pos = stepped[PTR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pos <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o = st_q.pos;

endmodule

// File: rtl/crb_store.sv
module crb_store #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PTR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] ent;
    } store_state_t;

    store_state_t     st_d, st_q;
    logic [DEPTH-1:0] hit;

    // One write-enable decode per entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_dec
        assign hit[g] = we && (waddr == PTR_W'(g));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit[i]) begin
                st_d.ent[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.ent[raddr];

endmodule

// File: rtl/circ_read_buf.sv
module circ_read_buf #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SIZE_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic              cfg_take;
    logic [SIZE_W-1:0] size_q;
    logic [PTR_W-1:0]  rd_pos;
    logic [PTR_W-1:0]  wr_pos;
    logic              rd_step;
    logic              wr_step;

    // An accepted configure takes priority over both access strobes.
    assign rd_step = rd_en && !cfg_take;
    assign wr_step = wr_en && !cfg_take;

    crb_cfg #(.DEPTH(DEPTH), .SIZE_W(SIZE_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_valid(cfg_valid),
        .cfg_size (cfg_size),
        .accept_o (cfg_take),
        .size_o   (size_q)
    );

    crb_ptr #(.PTR_W(PTR_W), .SIZE_W(SIZE_W)) u_rd_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(cfg_take),
        .step (rd_step),
        .size (size_q),
        .pos_o(rd_pos)
    );

    crb_ptr #(.PTR_W(PTR_W), .SIZE_W(SIZE_W)) u_wr_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(cfg_take),
        .step (wr_step),
        .size (size_q),
        .pos_o(wr_pos)
    );

    crb_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_step),
        .waddr(wr_pos),
        .wdata(wr_data),
        .raddr(rd_pos),
        .rdata(rd_data)
    );

endmodule

// File: rtl/crb_chk.sv
module crb_chk #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned SIZE_W = 4,
    parameter int unsigned PTR_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_valid,
    input logic [SIZE_W-1:0] cfg_size,
    input logic              rd_en,
    input logic              wr_en,
    input logic [SIZE_W-1:0] size,
    input logic [PTR_W-1:0]  rd_pos,
    input logic [PTR_W-1:0]  wr_pos
);

    logic good_cfg;
    assign good_cfg = cfg_valid && (cfg_size >= SIZE_W'(1)) && (cfg_size <= SIZE_W'(DEPTH));

    // R4
    rd_pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        SIZE_W'(rd_pos) < size);

    // R5
    wr_pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        SIZE_W'(wr_pos) < size);

    // R6
    cfg_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        good_cfg |=> (rd_pos == '0) && (wr_pos == '0) && (size == $past(cfg_size)));

    // R7
    bad_cfg_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !good_cfg) |=> $stable(size));

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !good_cfg) |=> $stable(rd_pos));

    // R3
    rd_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !good_cfg && (SIZE_W'(rd_pos) + SIZE_W'(1) < size))
        |=> (rd_pos == $past(rd_pos) + PTR_W'(1)));

    // R4
    rd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !good_cfg && (SIZE_W'(rd_pos) + SIZE_W'(1) == size))
        |=> (rd_pos == '0));

    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !good_cfg) |=> $stable(wr_pos));

endmodule

bind circ_read_buf crb_chk #(
    .DEPTH (DEPTH),
    .SIZE_W(SIZE_W),
    .PTR_W (PTR_W)
) u_crb_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_valid(cfg_valid),
    .cfg_size (cfg_size),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .size     (size_q),
    .rd_pos   (rd_pos),
    .wr_pos   (wr_pos)
);

// File: tb/test_circ_read_buf.sv
`timescale 1ns/1ps
module test_circ_read_buf;

    localparam int DEPTH  = 8;
    localparam int DATA_W = 32;
    localparam int SIZE_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_valid = 1'b0;
    logic [SIZE_W-1:0] cfg_size = '0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Behavioural reference state.
    logic [DATA_W-1:0] m_ent [DEPTH];
    int m_rp, m_wp, m_sz;

    always #10 clk = ~clk;

    circ_read_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) i_circ_read_buf (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_size(cfg_size),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
    );

    task automatic check(input string tag);
        checks++;
        if (rd_data !== m_ent[m_rp]) begin
            failures++;
            $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, m_ent[m_rp]);
        end
    endtask

    // One cycle: check current output, drive strobes, update model at the edge.
    task automatic cyc(input string tag, input bit c, input int s,
                       input bit w, input logic [DATA_W-1:0] d, input bit r);
        @(negedge clk);
        check(tag);
        cfg_valid = c; cfg_size = SIZE_W'(s); wr_en = w; wr_data = d; rd_en = r;
        @(posedge clk);
        if (c && s >= 1 && s <= DEPTH) begin
            m_sz = s; m_rp = 0; m_wp = 0;
        end else begin
            if (w) begin
                m_ent[m_wp] = d;
                m_wp = (m_wp + 1) % m_sz;
            end
            if (r) m_rp = (m_rp + 1) % m_sz;
        end
        #1;
        cfg_valid = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_ent[i] = '0;
        m_rp = 0; m_wp = 0; m_sz = DEPTH;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset contents and default size wrap over 8 entries
        for (int i = 0; i < 10; i++) cyc("R1", 0, 0, 0, '0, 1);

        // R5 / R2: fill all entries with distinct values, write pointer wraps
        for (int i = 0; i < DEPTH + 2; i++) cyc("R5", 0, 0, 1, 32'hA000_0000 + i, 0);
        // R3 / R4: read around the full buffer more than once
        for (int i = 0; i < 2 * DEPTH + 3; i++) cyc("R4", 0, 0, 0, '0, 1);

        // R6: configure size 3, entries retained, positions restart
        cyc("R6", 1, 3, 0, '0, 0);
        for (int i = 0; i < 4; i++) cyc("R6", 0, 0, 1, 32'hB000_0000 + i, 0);
        for (int i = 0; i < 8; i++) cyc("R4", 0, 0, 0, '0, 1);

        // R7: out-of-range configures ignored, same-cycle strobes still act
        cyc("R7", 1, 0, 0, '0, 1);
        cyc("R7", 1, 9, 1, 32'hC000_0001, 1);
        cyc("R7", 1, 15, 0, '0, 1);
        for (int i = 0; i < 6; i++) cyc("R7", 0, 0, 0, '0, 1);

        // R8: accepted configure suppresses same-cycle read and write
        cyc("R8", 0, 0, 0, '0, 1);
        cyc("R8", 1, 5, 1, 32'hDEAD_BEEF, 1);
        for (int i = 0; i < 7; i++) cyc("R8", 0, 0, 0, '0, 1);

        // R9: size 1 keeps returning and overwriting entry 0
        cyc("R9", 1, 1, 0, '0, 0);
        for (int i = 0; i < 4; i++) cyc("R9", 0, 0, 0, '0, 1);
        for (int i = 0; i < 3; i++) cyc("R9", 0, 0, 1, 32'hE000_0000 + i, 1);
        cyc("R9", 0, 0, 0, '0, 1);

        // R10: simultaneous read and write at full size
        cyc("R10", 1, DEPTH, 0, '0, 0);
        for (int i = 0; i < 2 * DEPTH; i++) cyc("R10", 0, 0, 1, 32'hF000_0000 + i, 1);
        for (int i = 0; i < DEPTH + 1; i++) cyc("R10", 0, 0, 0, '0, 1);

        // R2: output holds steady while idle
        cyc("R2", 0, 0, 0, '0, 0);
        cyc("R2", 0, 0, 0, '0, 0);
        @(negedge clk);
        check("R2");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule